// File: doc/BRIEF.md
# Retentive Operand Multiplexer Stage

This block selects the two operands of one shared adder in a scheduled datapath. Each operand port has a tree of 2-to-1 multibit multiplexers that picks one of several load-enabled source registers. The controller gives a select word per port and a single active bit for the unit. In the default dynamic mode, every multiplexer stage keeps its own one-bit select register. The register loads only while the unit is active. While the unit is idle, each stage keeps routing the source it chose in the last active cycle, so the adder inputs do not change and the adder makes no spurious transitions.

A parameter can pick a static mode instead. In static mode there are no hold registers, and the select words pass straight through every cycle. The controller is then expected to fill its idle-state don't-cares with the value from the most likely preceding state. The registered sum updates only in active cycles. One counter per port records idle cycles in which that operand changed anyway, which gives a direct measure of how well idle states are protected.

Top module: `retentive_operand_stage`

## Requirements
- R1: After reset, every held select bit is 0, so an idle unit routes source 0 on both ports. The registered sum and both idle-change counters are 0.
- R2: In a cycle with `unit_active` = 1, `opnd_a` equals source `sel_a` of `src_a` in that same cycle, and `opnd_b` equals source `sel_b` of `src_b`. Both operands are combinational.
- R3: In dynamic mode, while `unit_active` = 0, each port routes the source selected in the most recent active cycle, and the values on `sel_a` and `sel_b` have no effect.
- R4: In dynamic mode, an idle stretch in which no source register changes leaves both operands stable and both counters unchanged. A change to a source that is not selected also leaves the operand and the counter unchanged.
- R5: In the first active cycle after an idle stretch, the new select value takes effect in that same cycle, not one cycle later.
- R6: `sum_q` is (DATA_W+1) bits wide. One cycle after an active cycle it holds the zero-extended sum `opnd_a + opnd_b`, and it holds its value across idle cycles.
- R7: A port's counter increments by one at each clock edge that ends an idle cycle in which that port's operand differs from its value in the previous cycle. It never increments in active cycles, and it saturates at 2^CNT_W - 1.
- R8: In static mode (`MODE` = `RETAIN_STATIC`), the operands follow `sel_a` and `sel_b` in every cycle, whether the unit is active or idle.
- R9: A select value k picks source k, and source k occupies bits [k*DATA_W +: DATA_W] of its source bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| unit_active | input | 1 | 1 when the adder is scheduled in this state |
| sel_a | input | SEL_W | Controller select for port A (don't-care while idle) |
| sel_b | input | SEL_W | Controller select for port B (don't-care while idle) |
| src_a | input | NUM_SRC*DATA_W | Source registers available to port A |
| src_b | input | NUM_SRC*DATA_W | Source registers available to port B |
| opnd_a | output | DATA_W | Operand A presented to the adder |
| opnd_b | output | DATA_W | Operand B presented to the adder |
| sum_q | output | DATA_W+1 | Registered adder result |
| idle_chg_a | output | CNT_W | Idle-cycle operand changes on port A |
| idle_chg_b | output | CNT_W | Idle-cycle operand changes on port B |

## Verification
The operands are due in the same cycle as the select, active bit and source values that produce them. The bench drives inputs on the falling edge and checks the operands one nanosecond later, before the next rising edge. `sum_q` and the counters pass through exactly one register, so they are due after the rising edge that ends the stimulus cycle. The bench checks them one nanosecond after that edge, against a sum and a change count that it keeps itself. A second instance built in static mode gets the same stimulus, which checks that idle selects follow the controller in that mode.

// File: rtl/rom_pkg.sv
package rom_pkg;
   typedef enum logic {
      RETAIN_STATIC  = 1'b0,
      RETAIN_DYNAMIC = 1'b1
   } retain_mode_e;
endpackage

// File: rtl/sel_retain.sv
module sel_retain
   import rom_pkg::*;
#(
   parameter int           SEL_W = 2,
   parameter retain_mode_e MODE  = RETAIN_DYNAMIC
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en_i,
   input  logic [SEL_W-1:0] sel_i,
   output logic [SEL_W-1:0] sel_o
);
   generate
      if (MODE == RETAIN_DYNAMIC) begin : g_dyn
         for (genvar b = 0; b < SEL_W; b++) begin : g_bit
            logic held_q;
            always_ff @(posedge clk) begin
               if (!rst_n)    held_q <= 1'b0;
               else if (en_i) held_q <= sel_i[b];
            end
            assign sel_o[b] = en_i ? sel_i[b] : held_q;
         end

         // R3: first idle cycle routes the last active select
         p_first_idle_keeps_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (!en_i && $past(en_i)) |-> (sel_o == $past(sel_i)));
         // R3: controller select is ignored across idle cycles
         p_idle_ignores_ctrl_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (!en_i && !$past(en_i)) |-> $stable(sel_o));
      end else begin : g_stat
         assign sel_o = sel_i;
      end
   endgenerate
endmodule

// File: rtl/mux_tree.sv
module mux_tree #(
   parameter int DATA_W  = 8,
   parameter int NUM_SRC = 4,
   localparam int SEL_W  = $clog2(NUM_SRC)
) (
   input  logic [NUM_SRC*DATA_W-1:0] src_i,
   input  logic [SEL_W-1:0]          sel_i,
   output logic [DATA_W-1:0]         out_o
);
   localparam int NODES = 2*NUM_SRC - 1;

   logic [DATA_W-1:0] node [NODES];

   generate
      for (genvar i = 0; i < NUM_SRC; i++) begin : g_leaf
         assign node[NUM_SRC-1+i] = src_i[i*DATA_W +: DATA_W];
      end
      for (genvar k = 0; k < NUM_SRC-1; k++) begin : g_stage
         localparam int DEPTH = $clog2(k+2) - 1;
         assign node[k] = sel_i[SEL_W-1-DEPTH] ? node[2*k+2] : node[2*k+1];
      end
   endgenerate

   assign out_o = node[0];
endmodule

// File: rtl/idle_change_count.sv
module idle_change_count #(
   parameter int DATA_W = 8,
   parameter int CNT_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              active_i,
   input  logic [DATA_W-1:0] opnd_i,
   output logic [CNT_W-1:0]  cnt_o
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   logic [DATA_W-1:0] prev_q;
   logic              primed_q;
   logic [CNT_W-1:0]  cnt_q;
   logic              bump;

   assign bump = primed_q && !active_i && (opnd_i != prev_q) && (cnt_q != CNT_MAX);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev_q   <= '0;
         primed_q <= 1'b0;
         cnt_q    <= '0;
      end else begin
         prev_q   <= opnd_i;
         primed_q <= 1'b1;
         if (bump) cnt_q <= cnt_q + 1'b1;
      end
   end

   assign cnt_o = cnt_q;

   // R7: no counting in active cycles
   p_active_no_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
      active_i |=> $stable(cnt_q));
   // R7: the count never leaves the saturated value
   p_saturate_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX));
endmodule

// File: rtl/retentive_operand_stage.sv
module retentive_operand_stage
   import rom_pkg::*;
#(
   parameter int           DATA_W  = 8,
   parameter int           NUM_SRC = 4,
   parameter int           CNT_W   = 8,
   parameter retain_mode_e MODE    = RETAIN_DYNAMIC,
   localparam int          SEL_W   = $clog2(NUM_SRC),
   localparam int          BUS_W   = NUM_SRC*DATA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              unit_active,
   input  logic [SEL_W-1:0]  sel_a,
   input  logic [SEL_W-1:0]  sel_b,
   input  logic [BUS_W-1:0]  src_a,
   input  logic [BUS_W-1:0]  src_b,
   output logic [DATA_W-1:0] opnd_a,
   output logic [DATA_W-1:0] opnd_b,
   output logic [DATA_W:0]   sum_q,
   output logic [CNT_W-1:0]  idle_chg_a,
   output logic [CNT_W-1:0]  idle_chg_b
);
   generate
      if (NUM_SRC < 2 || (NUM_SRC & (NUM_SRC-1)) != 0) begin : g_bad_src
         $error("NUM_SRC must be a power of two, at least 2");
      end
      if (DATA_W < 1 || CNT_W < 1) begin : g_bad_w
         $error("DATA_W and CNT_W must be positive");
      end
   endgenerate

   logic [SEL_W-1:0] eff_a, eff_b;

   sel_retain #(.SEL_W(SEL_W), .MODE(MODE)) u_hold_a (
      .clk(clk), .rst_n(rst_n), .en_i(unit_active), .sel_i(sel_a), .sel_o(eff_a));
   sel_retain #(.SEL_W(SEL_W), .MODE(MODE)) u_hold_b (
      .clk(clk), .rst_n(rst_n), .en_i(unit_active), .sel_i(sel_b), .sel_o(eff_b));

   mux_tree #(.DATA_W(DATA_W), .NUM_SRC(NUM_SRC)) u_tree_a (
      .src_i(src_a), .sel_i(eff_a), .out_o(opnd_a));
   mux_tree #(.DATA_W(DATA_W), .NUM_SRC(NUM_SRC)) u_tree_b (
      .src_i(src_b), .sel_i(eff_b), .out_o(opnd_b));

   always_ff @(posedge clk) begin
      if (!rst_n)           sum_q <= '0;
      else if (unit_active) sum_q <= {1'b0, opnd_a} + {1'b0, opnd_b};
   end

   idle_change_count #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_cnt_a (
      .clk(clk), .rst_n(rst_n), .active_i(unit_active), .opnd_i(opnd_a), .cnt_o(idle_chg_a));
   idle_change_count #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_cnt_b (
      .clk(clk), .rst_n(rst_n), .active_i(unit_active), .opnd_i(opnd_b), .cnt_o(idle_chg_b));

   // R6: result captured from the operands of an active cycle
   p_sum_capture_r6: assert property (@(posedge clk) disable iff (!rst_n)
      unit_active |=> (sum_q == ({1'b0, $past(opnd_a)} + {1'b0, $past(opnd_b)})));
   // R6: result frozen while idle
   p_sum_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !unit_active |=> $stable(sum_q));

   generate
      if (MODE == RETAIN_DYNAMIC) begin : g_dyn_chk
         // R4: idle with steady sources keeps the operands steady
         p_idle_opnd_a_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (!unit_active && $stable(src_a)) |-> $stable(opnd_a));
         p_idle_opnd_b_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (!unit_active && $stable(src_b)) |-> $stable(opnd_b));
      end
   endgenerate
endmodule

// File: tb/sim_retentive_operand_stage.sv
`timescale 1ns/1ps
module sim_retentive_operand_stage;
   import rom_pkg::*;

   localparam int DW = 8;
   localparam int NS = 4;
   localparam int CW = 8;
   localparam int SW = 2;

   typedef struct packed {
      logic          act;
      logic [SW-1:0] sa;
      logic [SW-1:0] sb;
      logic [DW-1:0] ea;
      logic [DW-1:0] eb;
   } vec_t;

   // sources A: 11,22,33,44 ; sources B: 05,15,25,35
   localparam vec_t VEC [8] = '{
      '{1'b1, 2'd0, 2'd0, 8'h11, 8'h05},
      '{1'b1, 2'd2, 2'd1, 8'h33, 8'h15},
      '{1'b0, 2'd1, 2'd3, 8'h33, 8'h15},
      '{1'b0, 2'd3, 2'd0, 8'h33, 8'h15},
      '{1'b1, 2'd3, 2'd3, 8'h44, 8'h35},
      '{1'b0, 2'd0, 2'd2, 8'h44, 8'h35},
      '{1'b1, 2'd1, 2'd2, 8'h22, 8'h25},
      '{1'b1, 2'd0, 2'd0, 8'h11, 8'h05}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic act = 1'b0;
   logic [SW-1:0] sa = '0, sb = '0;
   logic [DW-1:0] arr_a [NS];
   logic [DW-1:0] arr_b [NS];
   logic [NS*DW-1:0] src_a, src_b;
   logic [DW-1:0] oa0, ob0, oa1, ob1;
   logic [DW:0]   s0, s1;
   logic [CW-1:0] ca0, cb0, ca1, cb1;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;
   logic [DW:0] exp_sum;

   always #2.5 clk = ~clk;

   always_comb begin
      for (int i = 0; i < NS; i++) begin
         src_a[i*DW +: DW] = arr_a[i];
         src_b[i*DW +: DW] = arr_b[i];
      end
   end

   retentive_operand_stage #(.DATA_W(DW), .NUM_SRC(NS), .CNT_W(CW), .MODE(RETAIN_DYNAMIC)) u0 (
      .clk(clk), .rst_n(rst_n), .unit_active(act), .sel_a(sa), .sel_b(sb),
      .src_a(src_a), .src_b(src_b), .opnd_a(oa0), .opnd_b(ob0), .sum_q(s0),
      .idle_chg_a(ca0), .idle_chg_b(cb0));

   retentive_operand_stage #(.DATA_W(DW), .NUM_SRC(NS), .CNT_W(CW), .MODE(RETAIN_STATIC)) u1 (
      .clk(clk), .rst_n(rst_n), .unit_active(act), .sel_a(sa), .sel_b(sb),
      .src_a(src_a), .src_b(src_b), .opnd_a(oa1), .opnd_b(ob1), .sum_q(s1),
      .idle_chg_a(ca1), .idle_chg_b(cb1));

   task automatic chk(input string rq, input logic [31:0] actv, input logic [31:0] expv);
      n_cmp++;
      if (actv !== expv) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", rq, actv, expv);
      end
   endtask

   initial begin
      for (int i = 0; i < NS; i++) begin
         arr_a[i] = 8'h11 * (i + 1);
         arr_b[i] = 8'h05 + 8'h10 * i;
      end
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1: reset state
      chk("R1 opnd_a", oa0, 8'h11);
      chk("R1 opnd_b", ob0, 8'h05);
      chk("R1 sum", s0, 0);
      chk("R1 cnt_a", ca0, 0);
      chk("R1 cnt_b", cb0, 0);
      exp_sum = '0;

      // table walk: R2 (active), R3 (idle hold), R5, R6, R8, R9
      for (int r = 0; r < 8; r++) begin
         @(negedge clk);
         act = VEC[r].act; sa = VEC[r].sa; sb = VEC[r].sb;
         #1;
         chk(VEC[r].act ? "R2 opnd_a" : "R3 opnd_a", oa0, VEC[r].ea);
         chk(VEC[r].act ? "R2 opnd_b" : "R3 opnd_b", ob0, VEC[r].eb);
         chk("R8 static opnd_a", oa1, arr_a[VEC[r].sa]);
         chk("R8 static opnd_b", ob1, arr_b[VEC[r].sb]);
         if (VEC[r].act) exp_sum = {1'b0, VEC[r].ea} + {1'b0, VEC[r].eb};
         @(posedge clk); #1;
         chk("R6 sum", s0, exp_sum);
         chk("R4 cnt_a", ca0, 0);
         chk("R4 cnt_b", cb0, 0);
      end

      // idle; controller select ignored
      @(negedge clk);
      act = 1'b0; sa = 2'd3; sb = 2'd3;
      #1;
      chk("R3 opnd_a idle", oa0, 8'h11);
      chk("R3 opnd_b idle", ob0, 8'h05);
      @(posedge clk); #1;
      chk("R4 cnt_a idle", ca0, 0);

      // held source loaded during idle
      @(negedge clk);
      arr_a[0] = 8'h77;
      #1;
      chk("R7 opnd_a follows load", oa0, 8'h77);
      @(posedge clk); #1;
      chk("R7 cnt_a one", ca0, 1);
      chk("R7 cnt_b zero", cb0, 0);

      // unselected source loaded during idle
      @(negedge clk);
      arr_a[1] = 8'h99;
      #1;
      chk("R4 opnd_a unselected", oa0, 8'h77);
      @(posedge clk); #1;
      chk("R4 cnt_a unselected", ca0, 1);

      // first active cycle uses new select at once
      @(negedge clk);
      act = 1'b1; sa = 2'd1; sb = 2'd2;
      #1;
      chk("R5 opnd_a", oa0, 8'h99);
      chk("R5 opnd_b", ob0, 8'h25);
      @(posedge clk); #1;
      chk("R6 sum after R5", s0, 9'h0BE);
      chk("R7 cnt_a active", ca0, 1);

      // saturation: held source 1 toggles every idle cycle
      @(negedge clk);
      act = 1'b0; sa = 2'd0;
      for (int t = 0; t < 300; t++) begin
         @(negedge clk);
         arr_a[1] = ~arr_a[1];
      end
      @(posedge clk); #1;
      chk("R7 cnt_a saturated", ca0, 8'hFF);
      chk("R6 sum idle hold", s0, 9'h0BE);
      chk("R9 opnd_a source1", oa0, arr_a[1]);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #200000;
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule